// File: doc/BRIEF.md
# Configuration Request PIO Engine

This block lets a host issue PCIe configuration reads and writes one at a time through a small register file. Software sets the request type, the address, the write data and a byte-lane strobe, then writes the launch bit. The engine places one request on a valid/ready channel toward the link side and waits for a completion on a separate completion port. It then stores the returned data and a 3-bit completion code and raises a done flag that software clears by writing 1.

Only one transfer can be in flight. A launch written while a transfer is active is dropped and recorded as an overrun. A programmable cycle budget bounds every transfer. When the budget runs out, the engine ends the transfer as a completer abort and returns all-ones data. Request types whose top bit is clear are posted: they finish when the link side accepts them.

Register word index on `reg_addr`:

| Index | Register |
|---|---|
| 0 | CTRL |
| 1 | STAT |
| 2 | ADDR_LO |
| 3 | ADDR_HI |
| 4 | WDATA |
| 5 | STRB |
| 6 | RDATA |
| 7 | START |
| 8 | DONE |
| 9 | TMO |

Top module: `cfg_pio_engine`

## Requirements
- R1: After reset, every register reads zero except TMO, which reads its default (1024). `req_valid` and `done_irq` are low.
- R2: A write with bit 0 set to START (index 7) while idle launches a transfer. From the next cycle the engine holds `req_valid` high until `req_ready`, with all request fields stable. The request carries `req_kind` = CTRL[3:0], `req_bypass` = CTRL[24], `req_wdata` = WDATA and `req_strb` = STRB[3:0]. `req_addr` is ADDR_LO aligned down to a multiple of 4, with the upper 32 bits forced to zero.
- R3: START bit 0 reads 1 from the cycle after launch until the transfer ends, and reads 0 otherwise.
- R4: For a non-posted request, the engine accepts the first `cpl_valid` after the handshake. It stores `cpl_data` in RDATA and `cpl_status` unchanged in STAT[9:7] (0 success, 1 unsupported, 2 retry, 4 abort; any other code is kept as is). START then reads 0 and DONE bit 0 reads 1 from the same cycle.
- R5: STAT[10] is set when the last request had `req_kind[3]`=1 (types 0x8–0xB are non-posted). A request with `req_kind[3]`=0 is posted. It ends at the handshake with STAT[9:7]=0 and STAT[10]=0, and RDATA keeps its value.
- R6: Writing 1 to DONE bit 0 clears the flag. Writing 0 leaves it unchanged. `done_irq` follows the flag.
- R7: A START write while a transfer is active does not disturb that transfer and issues no second request. It sets the sticky STAT[11], which only a write of 1 to STAT[11] clears.
- R8: A transfer still open TMO+1 cycles after launch ends with STAT[9:7]=4, RDATA=all ones, DONE set and `req_valid` low.
- R9: A `cpl_valid` while no transfer waits for a completion changes neither RDATA, STAT nor DONE.
- R10: CTRL reads back bits [3:0] and bit 24 as written, and all its other bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| req_valid | output | 1 | Request valid |
| req_ready | input | 1 | Request accepted by link side |
| req_kind | output | 4 | Request type code |
| req_bypass | output | 1 | Skip address-window mapping |
| req_addr | output | 64 | Aligned request address |
| req_wdata | output | 32 | Write payload |
| req_strb | output | 4 | Byte-lane strobe |
| cpl_valid | input | 1 | Completion valid |
| cpl_status | input | 3 | Completion code |
| cpl_data | input | 32 | Completion read data |
| done_irq | output | 1 | Done flag |

## Verification
A corrupted phase register shows at once on START, which reads busy with no request outstanding or idle while `req_valid` is high. It also shows within a cycle as a second request or a lost completion. Damage to the latched request fields appears at the handshake as a misaligned or wrong address, type or strobe. A faulty timeout counter shows as a transfer that ends one or more cycles away from TMO+1. Errors in status capture show in STAT or RDATA on the first read after DONE rises.

// File: rtl/cfg_pio_pkg.sv
package cfg_pio_pkg;
    localparam int RA_W = 4;

    localparam logic [RA_W-1:0] IX_CTRL  = 4'd0;
    localparam logic [RA_W-1:0] IX_STAT  = 4'd1;
    localparam logic [RA_W-1:0] IX_ALO   = 4'd2;
    localparam logic [RA_W-1:0] IX_AHI   = 4'd3;
    localparam logic [RA_W-1:0] IX_WDAT  = 4'd4;
    localparam logic [RA_W-1:0] IX_STRB  = 4'd5;
    localparam logic [RA_W-1:0] IX_RDAT  = 4'd6;
    localparam logic [RA_W-1:0] IX_START = 4'd7;
    localparam logic [RA_W-1:0] IX_DONE  = 4'd8;
    localparam logic [RA_W-1:0] IX_TMO   = 4'd9;

    localparam int CTRL_BYP_BIT = 24;
    localparam int ST_CODE_LSB  = 7;
    localparam int ST_NP_BIT    = 10;
    localparam int ST_OVR_BIT   = 11;

    localparam logic [2:0] CODE_OK    = 3'd0;
    localparam logic [2:0] CODE_ABORT = 3'd4;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_REQ  = 2'd1,
        PH_WAIT = 2'd2
    } phase_e;
endpackage

// File: rtl/cfg_pio_timer.sv
module cfg_pio_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         clear,
    input  logic [W-1:0] limit,
    output logic         hit
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear)
            cnt_d = '0;
        else if (run && (cnt_q != limit))
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign hit = run && (cnt_q == limit);
endmodule

// File: rtl/cfg_pio_rdmux.sv
module cfg_pio_rdmux
    import cfg_pio_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int STRB_W = 4,
    parameter int TMO_W  = 16
) (
    input  logic [RA_W-1:0]   sel,
    input  logic [3:0]        kind,
    input  logic              bypass,
    input  logic [2:0]        code,
    input  logic              nonposted,
    input  logic              overrun,
    input  logic [DATA_W-1:0] addr_lo,
    input  logic [DATA_W-1:0] addr_hi,
    input  logic [DATA_W-1:0] wdata,
    input  logic [STRB_W-1:0] strb,
    input  logic [DATA_W-1:0] rdata,
    input  logic              busy,
    input  logic              done,
    input  logic [TMO_W-1:0]  tmo_lim,
    output logic [DATA_W-1:0] out
);
    always_comb begin
        out = '0;
        unique case (sel)
            IX_CTRL: begin
                out[3:0]          = kind;
                out[CTRL_BYP_BIT] = bypass;
            end
            IX_STAT: begin
                out[ST_CODE_LSB +: 3] = code;
                out[ST_NP_BIT]        = nonposted;
                out[ST_OVR_BIT]       = overrun;
            end
            IX_ALO:   out = addr_lo;
            IX_AHI:   out = addr_hi;
            IX_WDAT:  out = wdata;
            IX_STRB:  out[STRB_W-1:0] = strb;
            IX_RDAT:  out = rdata;
            IX_START: out[0] = busy;
            IX_DONE:  out[0] = done;
            IX_TMO:   out[TMO_W-1:0] = tmo_lim;
            default:  out = '0;
        endcase
    end
endmodule

// File: rtl/cfg_pio_engine.sv
module cfg_pio_engine
    import cfg_pio_pkg::*;
#(
    parameter int              DATA_W  = 32,
    parameter int              ADDR_W  = 64,
    parameter int              TMO_W   = 16,
    parameter logic [TMO_W-1:0] TMO_DEF = 16'd1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [3:0]        req_kind,
    output logic              req_bypass,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W/8-1:0] req_strb,
    input  logic              cpl_valid,
    input  logic [2:0]        cpl_status,
    input  logic [DATA_W-1:0] cpl_data,
    output logic              done_irq
);
    localparam int STRB_W = DATA_W / 8;
    localparam int ALIGN  = $clog2(STRB_W);

    typedef struct packed {
        phase_e              phase;
        logic [3:0]          kind;
        logic                bypass;
        logic [DATA_W-1:0]   addr_lo;
        logic [DATA_W-1:0]   addr_hi;
        logic [DATA_W-1:0]   wdata;
        logic [STRB_W-1:0]   strb;
        logic [DATA_W-1:0]   rdata;
        logic [2:0]          code;
        logic                nonposted;
        logic                overrun;
        logic                done;
        logic [TMO_W-1:0]    tmo_lim;
        logic [3:0]          o_kind;
        logic                o_byp;
        logic [DATA_W-1:0]   o_addr;
        logic [DATA_W-1:0]   o_wdata;
        logic [STRB_W-1:0]   o_strb;
    } eng_t;

    eng_t st_d, st_q;
    logic launch;
    logic busy;
    logic tmo_hit;
    logic overrun;
    logic [2:0] cpl_code;

    assign busy     = (st_q.phase != PH_IDLE);
    assign overrun  = st_q.overrun;
    assign cpl_code = st_q.code;

    cfg_pio_timer #(.W(TMO_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .clear (launch),
        .limit (st_q.tmo_lim),
        .hit   (tmo_hit)
    );

    always_comb begin
        st_d   = st_q;
        launch = 1'b0;

        if (reg_wr) begin
            unique case (reg_addr)
                IX_CTRL: begin
                    st_d.kind   = reg_wdata[3:0];
                    st_d.bypass = reg_wdata[CTRL_BYP_BIT];
                end
                IX_STAT:  if (reg_wdata[ST_OVR_BIT]) st_d.overrun = 1'b0;
                IX_ALO:   st_d.addr_lo = reg_wdata;
                IX_AHI:   st_d.addr_hi = reg_wdata;
                IX_WDAT:  st_d.wdata   = reg_wdata;
                IX_STRB:  st_d.strb    = reg_wdata[STRB_W-1:0];
                IX_START: begin
                    if (reg_wdata[0]) begin
                        if (busy) st_d.overrun = 1'b1;
                        else      launch       = 1'b1;
                    end
                end
                IX_DONE:  if (reg_wdata[0]) st_d.done = 1'b0;
                IX_TMO:   st_d.tmo_lim = reg_wdata[TMO_W-1:0];
                default: ;
            endcase
        end

        unique case (st_q.phase)
            PH_IDLE: begin
                if (launch) begin
                    st_d.phase   = PH_REQ;
                    st_d.o_kind  = st_q.kind;
                    st_d.o_byp   = st_q.bypass;
                    st_d.o_addr  = {st_q.addr_lo[DATA_W-1:ALIGN], {ALIGN{1'b0}}};
                    st_d.o_wdata = st_q.wdata;
                    st_d.o_strb  = st_q.strb;
                end
            end
            PH_REQ: begin
                if (req_ready) begin
                    if (st_q.o_kind[3]) begin
                        st_d.phase = PH_WAIT;
                    end else begin
                        st_d.phase     = PH_IDLE;
                        st_d.done      = 1'b1;
                        st_d.code      = CODE_OK;
                        st_d.nonposted = 1'b0;
                    end
                end else if (tmo_hit) begin
                    st_d.phase     = PH_IDLE;
                    st_d.done      = 1'b1;
                    st_d.code      = CODE_ABORT;
                    st_d.rdata     = '1;
                    st_d.nonposted = st_q.o_kind[3];
                end
            end
            PH_WAIT: begin
                if (cpl_valid) begin
                    st_d.phase     = PH_IDLE;
                    st_d.done      = 1'b1;
                    st_d.code      = cpl_status;
                    st_d.rdata     = cpl_data;
                    st_d.nonposted = 1'b1;
                end else if (tmo_hit) begin
                    st_d.phase     = PH_IDLE;
                    st_d.done      = 1'b1;
                    st_d.code      = CODE_ABORT;
                    st_d.rdata     = '1;
                    st_d.nonposted = 1'b1;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.phase   <= PH_IDLE;
            st_q.tmo_lim <= TMO_DEF;
        end else begin
            st_q <= st_d;
        end
    end

    cfg_pio_rdmux #(.DATA_W(DATA_W), .STRB_W(STRB_W), .TMO_W(TMO_W)) u_rdmux (
        .sel       (reg_addr),
        .kind      (st_q.kind),
        .bypass    (st_q.bypass),
        .code      (st_q.code),
        .nonposted (st_q.nonposted),
        .overrun   (st_q.overrun),
        .addr_lo   (st_q.addr_lo),
        .addr_hi   (st_q.addr_hi),
        .wdata     (st_q.wdata),
        .strb      (st_q.strb),
        .rdata     (st_q.rdata),
        .busy      (busy),
        .done      (st_q.done),
        .tmo_lim   (st_q.tmo_lim),
        .out       (reg_rdata)
    );

    assign req_valid  = (st_q.phase == PH_REQ);
    assign req_kind   = st_q.o_kind;
    assign req_bypass = st_q.o_byp;
    assign req_addr   = {{(ADDR_W-DATA_W){1'b0}}, st_q.o_addr};
    assign req_wdata  = st_q.o_wdata;
    assign req_strb   = st_q.o_strb;
    assign done_irq   = st_q.done;
endmodule

// File: rtl/cfg_pio_checker.sv
module cfg_pio_checker #(
    parameter int ADDR_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              overrun,
    input logic              tmo_hit,
    input logic [2:0]        code,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic              cpl_valid,
    input logic              start_wr
);
    assert_hold_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready && !tmo_hit) |=> (req_valid && $stable(req_addr)));

    assert_addr_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_addr[1:0] == 2'b00 && req_addr[ADDR_W-1:32] == '0));

    assert_busy_with_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> busy);

    assert_done_on_finish_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_overrun_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_wr && busy) |=> (overrun && busy));

    assert_timeout_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && tmo_hit && !(req_valid && req_ready) && !(!req_valid && cpl_valid))
        |=> (!busy && done && code == 3'd4));
endmodule

bind cfg_pio_engine cfg_pio_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done_irq),
    .overrun   (overrun),
    .tmo_hit   (tmo_hit),
    .code      (cpl_code),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .cpl_valid (cpl_valid),
    .start_wr  (reg_wr && (reg_addr == 4'd7) && reg_wdata[0])
);

// File: tb/cfg_pio_engine_tb.sv
module cfg_pio_engine_tb;
    localparam logic [3:0] A_CTRL = 4'd0, A_STAT = 4'd1, A_ALO = 4'd2, A_AHI = 4'd3,
                           A_WDAT = 4'd4, A_STRB = 4'd5, A_RDAT = 4'd6, A_START = 4'd7,
                           A_DONE = 4'd8, A_TMO = 4'd9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req_valid, req_bypass;
    logic        req_ready = 1'b0;
    logic [3:0]  req_kind;
    logic [63:0] req_addr;
    logic [31:0] req_wdata;
    logic [3:0]  req_strb;
    logic        cpl_valid = 1'b0;
    logic [2:0]  cpl_status = '0;
    logic [31:0] cpl_data = '0;
    logic        done_irq;

    int n_chk = 0, n_fail = 0;

    // link-side model controls and capture
    int          rsp_lat = 0, hold_cnt = 0, seen = 0, lat_cnt = 0;
    bit          silent = 1'b0, stray = 1'b0, pend = 1'b0;
    logic [2:0]  rsp_st = '0;
    logic [31:0] rsp_data = '0;
    logic [3:0]  c_kind;
    logic        c_byp;
    logic [63:0] c_addr;
    logic [31:0] c_wdata;
    logic [3:0]  c_strb;
    logic [31:0] last_rd = '0;

    always #2 clk = ~clk;

    cfg_pio_engine u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
        .req_ready(req_ready), .req_kind(req_kind), .req_bypass(req_bypass),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_strb(req_strb),
        .cpl_valid(cpl_valid), .cpl_status(cpl_status), .cpl_data(cpl_data),
        .done_irq(done_irq)
    );

    initial begin
        forever begin
            @(negedge clk);
            cpl_valid = 1'b0;
            if (stray) begin
                cpl_valid = 1'b1; cpl_status = 3'd1; cpl_data = 32'h5A5A_0001; stray = 1'b0;
            end
            if (pend) begin
                if (lat_cnt == 0) begin
                    cpl_valid = 1'b1; cpl_status = rsp_st; cpl_data = rsp_data; pend = 1'b0;
                end else lat_cnt--;
            end
            req_ready = (hold_cnt == 0);
            if (req_valid && hold_cnt != 0) hold_cnt--;
            if (req_valid && req_ready) begin
                seen++;
                c_kind = req_kind; c_byp = req_bypass; c_addr = req_addr;
                c_wdata = req_wdata; c_strb = req_strb;
                if (req_kind[3] && !silent) begin pend = 1'b1; lat_cnt = rsp_lat; end
            end
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    function automatic logic [63:0] exp_addr(input logic [31:0] lo);
        return {32'h0, lo[31:2], 2'b00};
    endfunction

    function automatic logic [31:0] exp_stat(input logic [2:0] code, input logic np);
        return (32'(np) << 10) | (32'(code) << 7);
    endfunction

    task automatic run_txn(input logic [3:0] kind, input logic byp, input logic [31:0] lo,
                           input logic [31:0] wd, input logic [3:0] sb, input int lat,
                           input logic [2:0] st, input logic [31:0] data, input string tag);
        logic [31:0] v;
        int seen0;
        bit ended;
        wr(A_CTRL, {7'b0, byp, 20'b0, kind});
        wr(A_ALO, lo);
        wr(A_AHI, 32'hFFFF_0000);
        wr(A_WDAT, wd);
        wr(A_STRB, {28'b0, sb});
        wr(A_DONE, 32'h1);
        rsp_lat = lat; rsp_st = st; rsp_data = data;
        seen0 = seen;
        wr(A_START, 32'h1);
        ended = 1'b0;
        for (int i = 0; i < 300; i++) begin
            rd(A_START, v);
            if (v[0] == 1'b0) begin ended = 1'b1; break; end
            @(negedge clk);
        end
        chk({tag, " R3 transfer ends"}, ended, 1'b1);
        rd(A_DONE, v);
        chk({tag, " R4 done with start clear"}, v, 32'h1);
        chk({tag, " R2 one request"}, seen - seen0, 1);
        chk({tag, " R2 kind"}, c_kind, kind);
        chk({tag, " R2 bypass"}, c_byp, byp);
        chk({tag, " R2 addr aligned"}, c_addr, exp_addr(lo));
        chk({tag, " R2 wdata"}, c_wdata, wd);
        chk({tag, " R2 strobe"}, c_strb, sb);
        rd(A_STAT, v);
        if (kind[3]) begin
            chk({tag, " R4 status"}, v, exp_stat(st, 1'b1));
            last_rd = data;
        end else begin
            chk({tag, " R5 posted status"}, v, exp_stat(3'd0, 1'b0));
        end
        rd(A_RDAT, v);
        chk({tag, " R4 R5 rdata"}, v, last_rd);
    endtask

    initial begin
        #400us;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [2:0] codes [6];
        codes[0] = 3'd0; codes[1] = 3'd1; codes[2] = 3'd2;
        codes[3] = 3'd4; codes[4] = 3'd3; codes[5] = 3'd7;
        void'($urandom(32'd1234));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 10; a++) begin
            rd(4'(a), v);
            chk($sformatf("R1 reg %0d", a), v, (a == 9) ? 32'd1024 : 32'd0);
        end
        chk("R1 req_valid", req_valid, 1'b0);
        chk("R1 done_irq", done_irq, 1'b0);

        // R10 CTRL readback
        wr(A_CTRL, 32'hFFFF_FFFF);
        rd(A_CTRL, v);
        chk("R10 ctrl readback", v, 32'h0100_000F);

        wr(A_TMO, 32'd200);

        // directed: full-word type-0 read, then byte write at offset 3
        run_txn(4'h8, 1'b1, 32'h0012_3457, 32'h0, 4'hF, 0, 3'd0, 32'hCAFE_F00D, "dir rd0");
        run_txn(4'hB, 1'b0, 32'h0034_500B, 32'hAB00_0000, 4'h8, 3, 3'd1, 32'h0, "dir wr1");
        chk("R6 done_irq high", done_irq, 1'b1);

        // R6 done W1C
        wr(A_DONE, 32'h0);
        rd(A_DONE, v);
        chk("R6 write 0 keeps done", v, 32'h1);
        wr(A_DONE, 32'h1);
        rd(A_DONE, v);
        chk("R6 write 1 clears done", v, 32'h0);

        // R9 stray completion while idle
        stray = 1'b1;
        repeat (3) @(negedge clk);
        rd(A_DONE, v);  chk("R9 done unchanged", v, 32'h0);
        rd(A_RDAT, v);  chk("R9 rdata unchanged", v, last_rd);
        rd(A_STAT, v);  chk("R9 stat unchanged", v, exp_stat(3'd1, 1'b1));

        // ready held low for several cycles
        hold_cnt = 4;
        run_txn(4'h9, 1'b0, 32'h0100_0020, 32'h0, 4'hF, 1, 3'd2, 32'h1111_2222, "hold rd1");

        // R5 posted type
        run_txn(4'h4, 1'b0, 32'h0000_0010, 32'h7777_8888, 4'h3, 0, 3'd0, 32'h0, "R5 posted");

        // R7 overrun
        begin
            int s0;
            wr(A_CTRL, 32'h8); wr(A_ALO, 32'h40); wr(A_DONE, 32'h1);
            rsp_lat = 20; rsp_st = 3'd0; rsp_data = 32'h0BAD_CAFE;
            s0 = seen;
            wr(A_START, 32'h1);
            wr(A_ALO, 32'h80);
            wr(A_START, 32'h1);
            rd(A_STAT, v);
            chk("R7 overrun set", v[11], 1'b1);
            rd(A_START, v);
            chk("R7 first still busy", v, 32'h1);
            repeat (40) @(negedge clk);
            chk("R7 single request", seen - s0, 1);
            chk("R7 first address kept", c_addr, 64'h40);
            rd(A_RDAT, v);
            chk("R7 first completion kept", v, 32'h0BAD_CAFE);
            last_rd = 32'h0BAD_CAFE;
            rd(A_STAT, v);
            chk("R7 overrun sticky", v, exp_stat(3'd0, 1'b1) | 32'h800);
            wr(A_STAT, 32'h800);
            rd(A_STAT, v);
            chk("R7 overrun cleared", v, exp_stat(3'd0, 1'b1));
        end

        // R8 timeout with limit 6
        wr(A_TMO, 32'd6);
        silent = 1'b1;
        wr(A_CTRL, 32'hA); wr(A_DONE, 32'h1);
        wr(A_START, 32'h1);
        repeat (6) @(negedge clk);
        rd(A_START, v);
        chk("R8 busy at limit", v, 32'h1);
        @(negedge clk);
        rd(A_START, v);
        chk("R8 ended at limit+1", v, 32'h0);
        chk("R8 req dropped", req_valid, 1'b0);
        rd(A_STAT, v);  chk("R8 abort status", v, exp_stat(3'd4, 1'b1));
        rd(A_RDAT, v);  chk("R8 all ones", v, 32'hFFFF_FFFF);
        rd(A_DONE, v);  chk("R8 done", v, 32'h1);
        last_rd = 32'hFFFF_FFFF;
        silent = 1'b0;
        wr(A_TMO, 32'd200);

        // random mix
        for (int n = 0; n < 30; n++) begin
            logic [3:0] k;
            logic [1:0] off;
            int sz;
            logic [31:0] lo, val;
            k = ($urandom_range(0, 7) == 0) ? 4'h4 : (4'h8 | 4'($urandom_range(0, 3)));
            lo = $urandom;
            off = lo[1:0];
            sz = (off == 0) ? 4 : ((off == 2) ? 2 : 1);
            val = $urandom;
            val = (sz == 4) ? val : ((sz == 2) ? (val & 32'hFFFF) : (val & 32'hFF));
            run_txn(k, 1'($urandom_range(0, 1)), lo, val << (8 * off),
                    4'(((1 << sz) - 1) << off), $urandom_range(0, 6),
                    codes[$urandom_range(0, 5)], $urandom, $sformatf("rnd %0d", n));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule